// File: doc/BRIEF.md
# FP Load Slot Sequencer

This block follows a floating-point register load that uses a 12-bit displacement. It tracks the load through an integer pipeline and a floating-point pipeline that run side by side. The block accepts one instruction descriptor per slot. Each descriptor carries a valid bit, a flag that marks a floating-point load, a precision bit, a destination register index, and two source register indices, each with its own enable. The block decides in the current slot whether the presented instruction issues into decode or is held.

An instruction is held for one of two reasons. The slot directly after a double-precision load is always empty. A later instruction that reads a load's destination register waits until the load's store-to-register stage has completed. Each issued instruction produces one trace record. The record gives the slot in which the instruction decoded, how many slots it was held, and the stage it occupies in each slot of both pipelines. The block does no arithmetic, memory access or register data movement. It models only stage occupancy and hazard timing.

A three-entry window holds the pending loads. It shifts only when an instruction issues. Each entry counts down in wall-clock slots to the end of its load's store-to-register stage.

Top module: `fpl_slot_seq`

## Requirements
- R1: While reset is asserted, and once it has been released with no instruction presented, stall, contention, issue and trc_valid are all low. Reset also empties the hazard window, so an instruction that reads a register loaded before reset issues without delay.
- R2: For a single-precision load, the trace holds the integer-side sequence IF, ID, EX, MA and the floating-point-side sequence IF, DF, EX, NA, SF. Field i of trc_cpu or trc_fpu is at bits [3i+2:3i] and counts slots from the fetch slot. Integer codes are none=0, IF=1, ID=2, EX=3, MA=4. Floating-point codes are none=0, IF=1, DF=2, EX=3, NA=4, SF=5, E1=6, E2=7.
- R3: For a double-precision load, the trace holds the integer-side sequence IF, ID, EX, MA, MA and the floating-point-side sequence IF, DF, EX, EX, NA, SF, using the codes of R2.
- R4: For any instruction that is not a load, the trace holds the integer-side sequence IF, ID, EX and the floating-point-side sequence IF, DF, E1, E2, SF, using the codes of R2.
- R5: Nothing issues in the slot directly after a double-precision load issues. An instruction presented in that slot sees stall high and contention low.
- R6: Let a single-precision load issue in slot d, and let a reader of its destination be the k-th instruction after it (k = 1, 2 or 3), with no idle slots between them. That reader is held 4-k slots with contention high in each of them. At k = 4 it is not held.
- R7: Let a double-precision load issue in slot d. A reader at distance 1 is held 4 slots: 1 slot from R5 plus 3 slots with contention. Readers at distances 2 and 3 are held 2 and 1 slots with contention. A reader at distance 4 is not held.
- R8: A double-precision destination covers the register pair that differs only in bit 0, and a source matching either register is a hazard. A single-precision destination matches only its exact index.
- R9: Only instructions with the load flag set create hazards, and only source fields whose enable bit is set are compared (enable bit 0 covers in_src0, bit 1 covers in_src1).
- R10: Hazard timing runs in slots, not in instructions. Idle slots (in_valid low) between a load and its reader shorten the reader's hold by the same number of slots.
- R11: trc_valid is high exactly in the cycle after an issue. trc_wait gives the number of slots the instruction was held. trc_dec_slot gives the slot counter value in its issue slot, and that counter advances by one every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this slot |
| in_fpload | input | 1 | Presented instruction is a floating-point register load |
| in_dbl | input | 1 | Load is double precision |
| in_dst | input | REG_W | Destination register index |
| in_src_en | input | 2 | Enables for the two source fields |
| in_src0 | input | REG_W | First source register index |
| in_src1 | input | REG_W | Second source register index |
| stall | output | 1 | Presented instruction is held this slot |
| contention | output | 1 | Hold is caused by a read-after-write hazard |
| issue | output | 1 | Presented instruction enters decode this slot |
| trc_valid | output | 1 | A trace record is present |
| trc_dec_slot | output | SLOT_W | Slot counter value at decode |
| trc_wait | output | WAIT_W | Slots the instruction was held |
| trc_cpu | output | 15 | Integer-side stage codes, five 3-bit fields |
| trc_fpu | output | 18 | Floating-point-side stage codes, six 3-bit fields |

## Verification
The bench builds the block with its default parameters: a 4-bit register index, a 16-bit slot counter, a 4-bit hold counter and a 3-deep window. The 4-bit index gives enough even/odd pairs to test a double-precision destination from both its even and odd source registers, and to show a single-precision load ignoring its pair partner. The 3-deep window, combined with a reader at distance four, tests the exact edge of the hazard reach. The longest expected hold is 4 slots, well within the hold counter, so every held count is checked without saturation.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
  localparam int CODE_W    = 3;
  localparam int CPU_SLOTS = 5;
  localparam int FPU_SLOTS = 6;
  localparam int CNT_W     = 3;
  // slots from issue until the store-to-register stage has finished
  localparam int SF_LAG_SP = 3;
  localparam int SF_LAG_DP = 4;

  typedef enum logic [CODE_W-1:0] {
    CS_NONE = 3'd0, CS_IF = 3'd1, CS_ID = 3'd2, CS_EX = 3'd3, CS_MA = 3'd4
  } cpu_stage_e;

  typedef enum logic [CODE_W-1:0] {
    FS_NONE = 3'd0, FS_IF = 3'd1, FS_DF = 3'd2, FS_EX = 3'd3,
    FS_NA   = 3'd4, FS_SF = 3'd5, FS_E1 = 3'd6, FS_E2 = 3'd7
  } fpu_stage_e;
endpackage

// File: rtl/fpl_stage_map.sv
module fpl_stage_map
  import fpl_pkg::*;
(
  input  logic                          is_ld,
  input  logic                          is_dbl,
  output logic [CPU_SLOTS*CODE_W-1:0]   cpu_codes,
  output logic [FPU_SLOTS*CODE_W-1:0]   fpu_codes
);
  cpu_stage_e cs [CPU_SLOTS];
  fpu_stage_e fs [FPU_SLOTS];

  always_comb begin
    for (int i = 0; i < CPU_SLOTS; i++) cs[i] = CS_NONE;
    for (int i = 0; i < FPU_SLOTS; i++) fs[i] = FS_NONE;
    cs[0] = CS_IF;
    cs[1] = CS_ID;
    cs[2] = CS_EX;
    fs[0] = FS_IF;
    fs[1] = FS_DF;
    if (!is_ld) begin
      fs[2] = FS_E1;
      fs[3] = FS_E2;
      fs[4] = FS_SF;
    end else if (!is_dbl) begin
      cs[3] = CS_MA;
      fs[2] = FS_EX;
      fs[3] = FS_NA;
      fs[4] = FS_SF;
    end else begin
      // double precision occupies memory access and execute twice
      cs[3] = CS_MA;
      cs[4] = CS_MA;
      fs[2] = FS_EX;
      fs[3] = FS_EX;
      fs[4] = FS_NA;
      fs[5] = FS_SF;
    end
  end

  for (genvar g = 0; g < CPU_SLOTS; g++) begin : g_cpu
    assign cpu_codes[g*CODE_W +: CODE_W] = cs[g];
  end
  for (genvar g = 0; g < FPU_SLOTS; g++) begin : g_fpu
    assign fpu_codes[g*CODE_W +: CODE_W] = fs[g];
  end
endmodule

// File: rtl/fpl_hazard_win.sv
module fpl_hazard_win
  import fpl_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_ld,
  input  logic             push_dbl,
  input  logic [REG_W-1:0] push_dst,
  input  logic [1:0]       src_en,
  input  logic [REG_W-1:0] src0,
  input  logic [REG_W-1:0] src1,
  output logic             hazard
);
  logic             vld_q [DEPTH];
  logic             dbl_q [DEPTH];
  logic [REG_W-1:0] dst_q [DEPTH];
  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic             vld_d [DEPTH];
  logic             dbl_d [DEPTH];
  logic [REG_W-1:0] dst_d [DEPTH];
  logic [CNT_W-1:0] cnt_d [DEPTH];
  logic [CNT_W-1:0] cnt_dec [DEPTH];
  logic [DEPTH-1:0] hit;

  // next state: counters run every slot, entries shift only on issue
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cnt_dec[i] = (cnt_q[i] != '0) ? cnt_q[i] - 1'b1 : '0;
      vld_d[i]   = vld_q[i];
      dbl_d[i]   = dbl_q[i];
      dst_d[i]   = dst_q[i];
      cnt_d[i]   = cnt_dec[i];
    end
    if (push) begin
      vld_d[0] = push_ld;
      dbl_d[0] = push_dbl;
      dst_d[0] = push_dst;
      cnt_d[0] = !push_ld ? '0 : (push_dbl ? CNT_W'(SF_LAG_DP) : CNT_W'(SF_LAG_SP));
      for (int i = 1; i < DEPTH; i++) begin
        vld_d[i] = vld_q[i-1];
        dbl_d[i] = dbl_q[i-1];
        dst_d[i] = dst_q[i-1];
        cnt_d[i] = cnt_dec[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i] <= 1'b0;
        dbl_q[i] <= 1'b0;
        dst_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i] <= vld_d[i];
        dbl_q[i] <= dbl_d[i];
        dst_q[i] <= dst_d[i];
        cnt_q[i] <= cnt_d[i];
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic m0, m1;
    // a double destination covers the even/odd pair (R8)
    assign m0 = dbl_q[g] ? (src0[REG_W-1:1] == dst_q[g][REG_W-1:1]) : (src0 == dst_q[g]);
    assign m1 = dbl_q[g] ? (src1[REG_W-1:1] == dst_q[g][REG_W-1:1]) : (src1 == dst_q[g]);
    assign hit[g] = vld_q[g] && (cnt_q[g] != '0) &&
                    ((src_en[0] && m0) || (src_en[1] && m1));

    // pending counters drop by one per slot when no shift happens (R10)
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!push && cnt_q[g] != '0) |=> (cnt_q[g] == $past(cnt_q[g]) - 1'b1));
  end

  assign hazard = |hit;
endmodule

// File: rtl/fpl_slot_seq.sv
module fpl_slot_seq
  import fpl_pkg::*;
#(
  parameter int REG_W  = 4,
  parameter int SLOT_W = 16,
  parameter int WAIT_W = 4,
  parameter int DEPTH  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_fpload,
  input  logic                          in_dbl,
  input  logic [REG_W-1:0]              in_dst,
  input  logic [1:0]                    in_src_en,
  input  logic [REG_W-1:0]              in_src0,
  input  logic [REG_W-1:0]              in_src1,
  output logic                          stall,
  output logic                          contention,
  output logic                          issue,
  output logic                          trc_valid,
  output logic [SLOT_W-1:0]             trc_dec_slot,
  output logic [WAIT_W-1:0]             trc_wait,
  output logic [CPU_SLOTS*CODE_W-1:0]   trc_cpu,
  output logic [FPU_SLOTS*CODE_W-1:0]   trc_fpu
);
  localparam int CPU_W = CPU_SLOTS * CODE_W;
  localparam int FPU_W = FPU_SLOTS * CODE_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  logic              hazard;
  logic              dp_gap_q, dp_gap_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              tv_d;
  logic              trc_en;
  logic [SLOT_W-1:0] ts_d;
  logic [WAIT_W-1:0] tw_d;
  logic [CPU_W-1:0]  tc_d, map_cpu;
  logic [FPU_W-1:0]  tf_d, map_fpu;

  fpl_hazard_win #(.REG_W(REG_W), .DEPTH(DEPTH)) u_win (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .push     (issue),
    .push_ld  (in_fpload),
    .push_dbl (in_dbl),
    .push_dst (in_dst),
    .src_en   (in_src_en),
    .src0     (in_src0),
    .src1     (in_src1),
    .hazard   (hazard)
  );

  fpl_stage_map u_map (
    .is_ld     (in_fpload),
    .is_dbl    (in_dbl),
    .cpu_codes (map_cpu),
    .fpu_codes (map_fpu)
  );

  // issue decision for the presented instruction
  assign stall      = in_valid && (dp_gap_q || hazard);
  assign contention = in_valid && hazard && !dp_gap_q;
  assign issue      = in_valid && !stall;
  assign trc_en     = issue;

  always_comb begin
    dp_gap_d = issue && in_fpload && in_dbl;
    slot_d   = slot_q + 1'b1;
    wait_d   = wait_q;
    if (issue)                      wait_d = '0;
    else if (stall && wait_q != '1) wait_d = wait_q + 1'b1;
    tv_d = issue;
    ts_d = trc_dec_slot;
    tw_d = trc_wait;
    tc_d = trc_cpu;
    tf_d = trc_fpu;
    if (trc_en) begin
      ts_d = slot_q;
      tw_d = wait_q;
      tc_d = map_cpu;
      tf_d = map_fpu;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      dp_gap_q     <= 1'b0;
      slot_q       <= '0;
      wait_q       <= '0;
      trc_valid    <= 1'b0;
      trc_dec_slot <= '0;
      trc_wait     <= '0;
      trc_cpu      <= '0;
      trc_fpu      <= '0;
    end else begin
      dp_gap_q     <= dp_gap_d;
      slot_q       <= slot_d;
      wait_q       <= wait_d;
      trc_valid    <= tv_d;
      trc_dec_slot <= ts_d;
      trc_wait     <= tw_d;
      trc_cpu      <= tc_d;
      trc_fpu      <= tf_d;
    end
  end

  p_dp_gap_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (issue && in_fpload && in_dbl) |=> !issue);

  p_cont_held_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    contention |-> (stall && !issue));

  p_trc_rise_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    issue |=> trc_valid);

  p_trc_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !issue |=> !trc_valid);

  p_wait_clear_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    issue |=> (wait_q == '0));
endmodule

// File: tb/fpl_slot_seq_tb.sv
module fpl_slot_seq_tb;
  typedef struct packed {
    logic [2:0] idle;
    logic       ld;
    logic       dbl;
    logic [3:0] dst;
    logic [1:0] sen;
    logic [3:0] s0;
    logic [3:0] s1;
    logic [3:0] wt;
    logic [3:0] ct;
  } vec_t;

  localparam int NV = 39;
  // idle, ld, dbl, dst, sen, s0, s1, expected hold, expected contention slots
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b1, 1'b0, 4'd2,  2'b00, 4'd0,  4'd0,  4'd0, 4'd0}, // 0  SP load r2
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd2,  4'd0,  4'd3, 4'd3}, // 1  R6 distance 1
    '{3'd0, 1'b1, 1'b0, 4'd3,  2'b00, 4'd0,  4'd0,  4'd0, 4'd0}, // 2  SP load r3
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b00, 4'd3,  4'd3,  4'd0, 4'd0}, // 3  R9 sources disabled
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b10, 4'd0,  4'd3,  4'd2, 4'd2}, // 4  R6 distance 2 via src1
    '{3'd0, 1'b1, 1'b0, 4'd5,  2'b00, 4'd0,  4'd0,  4'd0, 4'd0}, // 5  SP load r5
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd1,  4'd0,  4'd0, 4'd0}, // 6
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd0,  4'd0,  4'd0, 4'd0}, // 7
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd5,  4'd0,  4'd1, 4'd1}, // 8  R6 distance 3
    '{3'd0, 1'b1, 1'b0, 4'd6,  2'b00, 4'd0,  4'd0,  4'd0, 4'd0}, // 9  SP load r6
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd0,  4'd0,  4'd0, 4'd0}, // 10
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd0,  4'd0,  4'd0, 4'd0}, // 11
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd0,  4'd0,  4'd0, 4'd0}, // 12
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd6,  4'd0,  4'd0, 4'd0}, // 13 R6 distance 4
    '{3'd0, 1'b1, 1'b0, 4'd6,  2'b00, 4'd0,  4'd0,  4'd0, 4'd0}, // 14 SP load r6
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd7,  4'd0,  4'd0, 4'd0}, // 15 R8 partner ignored
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd6,  4'd0,  4'd2, 4'd2}, // 16 R6 distance 2
    '{3'd0, 1'b1, 1'b1, 4'd8,  2'b00, 4'd0,  4'd0,  4'd0, 4'd0}, // 17 DP load r8/r9
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd9,  4'd0,  4'd4, 4'd3}, // 18 R7 R8 distance 1 odd
    '{3'd0, 1'b1, 1'b1, 4'd10, 2'b00, 4'd0,  4'd0,  4'd0, 4'd0}, // 19 DP load r10/r11
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd0,  4'd0,  4'd1, 4'd0}, // 20 R5 empty slot
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b10, 4'd0,  4'd10, 4'd2, 4'd2}, // 21 R7 distance 2
    '{3'd0, 1'b1, 1'b1, 4'd12, 2'b00, 4'd0,  4'd0,  4'd0, 4'd0}, // 22 DP load r12/r13
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd0,  4'd0,  4'd1, 4'd0}, // 23 R5
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd0,  4'd0,  4'd0, 4'd0}, // 24
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd13, 4'd0,  4'd1, 4'd1}, // 25 R7 distance 3
    '{3'd0, 1'b1, 1'b1, 4'd14, 2'b00, 4'd0,  4'd0,  4'd0, 4'd0}, // 26 DP load r14/r15
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd0,  4'd0,  4'd1, 4'd0}, // 27 R5
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd0,  4'd0,  4'd0, 4'd0}, // 28
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd0,  4'd0,  4'd0, 4'd0}, // 29
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd15, 4'd0,  4'd0, 4'd0}, // 30 R7 distance 4
    '{3'd0, 1'b1, 1'b1, 4'd0,  2'b00, 4'd0,  4'd0,  4'd0, 4'd0}, // 31 DP load r0/r1
    '{3'd0, 1'b1, 1'b1, 4'd2,  2'b00, 4'd0,  4'd0,  4'd1, 4'd0}, // 32 R5 DP after DP
    '{3'd0, 1'b1, 1'b0, 4'd4,  2'b00, 4'd0,  4'd0,  4'd1, 4'd0}, // 33 R5 SP after DP
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd4,  4'd0,  4'd3, 4'd3}, // 34 R6 distance 1
    '{3'd0, 1'b1, 1'b0, 4'd7,  2'b00, 4'd0,  4'd0,  4'd0, 4'd0}, // 35 SP load r7
    '{3'd2, 1'b0, 1'b0, 4'd0,  2'b01, 4'd7,  4'd0,  4'd1, 4'd1}, // 36 R10 two idle slots
    '{3'd0, 1'b0, 1'b0, 4'd9,  2'b00, 4'd0,  4'd0,  4'd0, 4'd0}, // 37 non-load writes r9
    '{3'd0, 1'b0, 1'b0, 4'd0,  2'b01, 4'd9,  4'd0,  4'd0, 4'd0}  // 38 R9 no hazard
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid, in_fpload, in_dbl;
  logic [3:0]  in_dst, in_src0, in_src1;
  logic [1:0]  in_src_en;
  logic        stall, contention, issue, trc_valid;
  logic [15:0] trc_dec_slot;
  logic [3:0]  trc_wait;
  logic [14:0] trc_cpu;
  logic [17:0] trc_fpu;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  fpl_slot_seq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fpload(in_fpload),
    .in_dbl(in_dbl), .in_dst(in_dst), .in_src_en(in_src_en),
    .in_src0(in_src0), .in_src1(in_src1), .stall(stall),
    .contention(contention), .issue(issue), .trc_valid(trc_valid),
    .trc_dec_slot(trc_dec_slot), .trc_wait(trc_wait),
    .trc_cpu(trc_cpu), .trc_fpu(trc_fpu)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [14:0] exp_cpu(input logic ld, input logic dbl);
    if (!ld)      return {3'd0, 3'd0, 3'd3, 3'd2, 3'd1};
    else if (dbl) return {3'd4, 3'd4, 3'd3, 3'd2, 3'd1};
    else          return {3'd0, 3'd4, 3'd3, 3'd2, 3'd1};
  endfunction

  function automatic logic [17:0] exp_fpu(input logic ld, input logic dbl);
    if (!ld)      return {3'd0, 3'd5, 3'd7, 3'd6, 3'd2, 3'd1};
    else if (dbl) return {3'd5, 3'd4, 3'd3, 3'd3, 3'd2, 3'd1};
    else          return {3'd0, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1};
  endfunction

  // present one instruction at a falling edge, hold it until it issues
  task automatic present(input logic ld, input logic dbl, input logic [3:0] dst,
                         input logic [1:0] sen, input logic [3:0] s0, input logic [3:0] s1,
                         output int w, output int c);
    in_valid  = 1'b1;
    in_fpload = ld;
    in_dbl    = dbl;
    in_dst    = dst;
    in_src_en = sen;
    in_src0   = s0;
    in_src1   = s1;
    w = 0;
    c = 0;
    forever begin
      #1;
      if (issue || w > 40) break;
      w++;
      if (contention) c++;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    int w, c;
    logic [15:0] prev;
    rst_n = 1'b0;
    in_valid = 1'b0; in_fpload = 1'b0; in_dbl = 1'b0;
    in_dst = '0; in_src_en = '0; in_src0 = '0; in_src1 = '0;
    prev = '0;
    repeat (3) @(negedge clk);
    check(stall == 1'b0 && contention == 1'b0, "R1 outputs low in reset", {stall, contention}, 0);
    check(trc_valid == 1'b0, "R1 trace low in reset", trc_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(issue == 1'b0 && stall == 1'b0, "R1 idle after release", {issue, stall}, 0);
    check(trc_valid == 1'b0, "R1 no trace when idle", trc_valid, 0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].idle != 0) begin
        @(negedge clk);
        check(trc_valid == 1'b0, "R11 trace drops in idle slot", trc_valid, 0);
        for (int j = 1; j < int'(VEC[k].idle); j++) @(negedge clk);
      end
      present(VEC[k].ld, VEC[k].dbl, VEC[k].dst, VEC[k].sen, VEC[k].s0, VEC[k].s1, w, c);
      // hold counts cover R5 R6 R7 R8 R9 R10
      check(w == int'(VEC[k].wt), $sformatf("R5 R6 R7 R8 R9 R10 hold vec %0d", k), w, int'(VEC[k].wt));
      check(c == int'(VEC[k].ct), $sformatf("R5 R6 R7 R8 R9 R10 contention vec %0d", k), c, int'(VEC[k].ct));
      check(trc_valid == 1'b1, $sformatf("R11 trace valid vec %0d", k), trc_valid, 1);
      check(trc_wait == VEC[k].wt, $sformatf("R11 trace wait vec %0d", k), trc_wait, int'(VEC[k].wt));
      check(trc_cpu == exp_cpu(VEC[k].ld, VEC[k].dbl),
            $sformatf("%s cpu codes vec %0d", VEC[k].ld ? (VEC[k].dbl ? "R3" : "R2") : "R4", k),
            int'(trc_cpu), int'(exp_cpu(VEC[k].ld, VEC[k].dbl)));
      check(trc_fpu == exp_fpu(VEC[k].ld, VEC[k].dbl),
            $sformatf("%s fpu codes vec %0d", VEC[k].ld ? (VEC[k].dbl ? "R3" : "R2") : "R4", k),
            int'(trc_fpu), int'(exp_fpu(VEC[k].ld, VEC[k].dbl)));
      if (k > 0)
        check(16'(trc_dec_slot - prev) == 16'(int'(VEC[k].idle) + int'(VEC[k].wt) + 1),
              $sformatf("R11 decode slot step vec %0d", k), int'(16'(trc_dec_slot - prev)),
              int'(VEC[k].idle) + int'(VEC[k].wt) + 1);
      prev = trc_dec_slot;
    end

    // R1: reset in mid-stream clears the pending load
    @(negedge clk);
    present(1'b1, 1'b1, 4'd3, 2'b00, 4'd0, 4'd0, w, c);
    rst_n = 1'b0;
    @(negedge clk);
    check(trc_valid == 1'b0, "R1 trace cleared by reset", trc_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    present(1'b0, 1'b0, 4'd0, 2'b01, 4'd3, 4'd0, w, c);
    check(w == 0, "R1 window emptied by reset", w, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule